// File: doc/BRIEF.md
# Master Interrupt Aggregator

This block sits at the top of a two-level interrupt tree. Each second-level group presents one 32-bit pending vector, which is that group's identity bits ANDed with its enable bits. A fixed map, supplied as a parameter table, gives each summary bit of a 32-bit master register one source group and one 32-bit mask. A summary bit reads 1 while the masked slice of its group's vector is non-zero and reads 0 otherwise. Because of the masks, one group can feed two summary bits, one from its low half and one from its high half.

Bit 31 of the master register is a global enable, and it is the only bit software can write. While the enable is 0 the summary bits are frozen and no request reaches the host. While the enable is 1 the summary bits follow the group vectors every cycle. The block then sends the host a one-cycle request pulse each time the condition "enabled and some summary bit set" goes from false to true.

A small state machine tracks that condition. Its states are `ST_OFF` (enable clear), `ST_ARMED` (enabled, nothing pending) and `ST_FIRED` (enabled, something pending). Its transitions are:
- OFF→ARMED: enable set and nothing pending.
- OFF→FIRED and ARMED→FIRED: enable set and something pending. Both of these emit the pulse.
- FIRED→ARMED: the pending bits clear.
- ARMED→OFF and FIRED→OFF: the enable clears.

Top module: `mirq_aggr`

## Requirements
- R1: A write (`wr_en_i`=1) loads only `wr_data_i[31]` into the enable at master bit 31. Bits 30..0 of the written value have no effect on the master register. Without a write the enable holds its value.
- R2: While the enable is 1, every mapped summary bit is level-tracked. It equals the OR of (group vector AND entry mask), sets and clears with its source, and updates one clock after the group input changes.
- R3: Half-word slices use these bit positions:
  - Group 0: bits 15..0 drive master bit 0, and bits 31..16 drive master bit 1.
  - Group 1: bits 15..0 drive master bit 2, and bits 31..16 drive master bit 3.
  - Group 2: bits 15..0 drive master bit 4.
  - Group 3: bits 15..0 drive master bit 6.
  - The high halves of groups 2 and 3 are ignored.
- R4: Whole-word groups map as follows:
  - Groups 4, 5 and 6 drive master bits 16, 17 and 18.
  - Group 7 drives bit 20.
  - Group 8 drives bit 22.
  - Group 9 drives bit 23.
  - Group 10 drives bit 30.
- R5: Master bits with no map entry always read 0: bits 5, 7 to 15, 19, 21 and 24 to 29.
- R6: While the enable is 0, the summary bits keep their values whatever the group inputs do, and `host_req_o` stays 0.
- R7: `host_req_o` is high for exactly one cycle, one clock after the first cycle in which the enable is 1 and any of master bits 30..0 is 1. It does not repeat while that condition stays true.
- R8: After reset the master register reads 0 and `host_req_o` is 0.
- R9: Setting the enable again while frozen summary bits are still 1 produces a new request pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| child_pend_i | input | 352 | Group vectors; group k occupies bits 32k+31..32k |
| wr_en_i | input | 1 | Software write strobe for the master register |
| wr_data_i | input | 32 | Write data; only bit 31 is used |
| master_o | output | 32 | Master register: bit 31 enable, remaining bits summary |
| host_req_o | output | 1 | One-cycle interrupt request toward the host |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:
- Half-word slicing. A mask error would show a high-half-only input on group 2 as bit 4, or swap bits 0 and 1.
- Writes carrying garbage in bits 30..0. A design that stored the whole word would show stray summary bits.
- All groups all-ones. A broken map would light an unmapped bit.
- Inputs changing while the enable is 0. A design that kept refreshing, or requested regardless of the enable, would change bits or pulse.
- The pulse edge. The bench holds a pending source for several cycles and also re-enables over frozen bits, which exposes a level-style request or a lost re-arm.

The random phase mixes sparse group changes and enable writes against a cycle-stepped model.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_CHILD = 11;
    localparam int CHILD_W   = $clog2(NUM_CHILD);
    localparam int SUM_W     = WORD_W - 1;

    localparam logic [WORD_W-1:0] LO_HALF = {{(WORD_W/2){1'b0}}, {(WORD_W/2){1'b1}}};
    localparam logic [WORD_W-1:0] HI_HALF = ~LO_HALF;
    localparam logic [WORD_W-1:0] WHOLE   = '1;

    typedef struct packed {
        logic               used;
        logic [CHILD_W-1:0] src;
        logic [WORD_W-1:0]  mask;
    } map_entry_t;

    typedef map_entry_t [SUM_W-1:0] map_tbl_t;

    function automatic map_entry_t mk(input int src, input logic [WORD_W-1:0] m);
        map_entry_t e;
        e.used = 1'b1;
        e.src  = CHILD_W'(src);
        e.mask = m;
        return e;
    endfunction

    function automatic map_tbl_t build_default_map();
        map_tbl_t t = '0;
        t[0]  = mk(0, LO_HALF);
        t[1]  = mk(0, HI_HALF);
        t[2]  = mk(1, LO_HALF);
        t[3]  = mk(1, HI_HALF);
        t[4]  = mk(2, LO_HALF);
        t[6]  = mk(3, LO_HALF);
        t[16] = mk(4, WHOLE);
        t[17] = mk(5, WHOLE);
        t[18] = mk(6, WHOLE);
        t[20] = mk(7, WHOLE);
        t[22] = mk(8, WHOLE);
        t[23] = mk(9, WHOLE);
        t[30] = mk(10, WHOLE);
        return t;
    endfunction

    function automatic logic [WORD_W-1:0] used_bits(input map_tbl_t t);
        logic [WORD_W-1:0] u = '0;
        for (int i = 0; i < SUM_W; i++) u[i] = t[i].used;
        return u;
    endfunction

    localparam map_tbl_t DEFAULT_MAP = build_default_map();
endpackage

// File: rtl/mirq_map_eval.sv
module mirq_map_eval
    import mirq_pkg::*;
#(
    parameter map_tbl_t MAP = DEFAULT_MAP
) (
    input  logic [NUM_CHILD*WORD_W-1:0] child_vec_i,
    output logic [SUM_W-1:0]            sum_o
);
    for (genvar b = 0; b < SUM_W; b++) begin : g_bit
        if (MAP[b].used) begin : g_mapped
            localparam int SRC = int'(MAP[b].src);
            assign sum_o[b] = |(child_vec_i[SRC*WORD_W +: WORD_W] & MAP[b].mask);
        end else begin : g_empty
            assign sum_o[b] = 1'b0;
        end
    end
endmodule

// File: rtl/mirq_req_fsm.sv
module mirq_req_fsm (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic any_i,
    output logic pulse_o
);
    typedef enum logic [1:0] {ST_OFF, ST_ARMED, ST_FIRED} req_state_t;

    req_state_t state_q, state_n;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_OFF;
        else         state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i && any_i)  state_n = ST_FIRED;
                else if (en_i)      state_n = ST_ARMED;
            end
            ST_ARMED: begin
                if (!en_i)          state_n = ST_OFF;
                else if (any_i)     state_n = ST_FIRED;
            end
            ST_FIRED: begin
                if (!en_i)          state_n = ST_OFF;
                else if (!any_i)    state_n = ST_ARMED;
            end
            default:                state_n = ST_OFF;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pulse_o <= 1'b0;
        else         pulse_o <= (state_n == ST_FIRED) && (state_q != ST_FIRED);
    end

    // R7: a pulse lasts one cycle
    assert_single_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

    // R7: a pulse follows a cycle with enable set and something pending
    assert_pulse_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pulse_o) |-> $past(en_i && any_i));
endmodule

// File: rtl/mirq_aggr.sv
module mirq_aggr
    import mirq_pkg::*;
#(
    parameter map_tbl_t MAP = DEFAULT_MAP
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [NUM_CHILD*WORD_W-1:0] child_pend_i,
    input  logic                        wr_en_i,
    input  logic [WORD_W-1:0]           wr_data_i,
    output logic [WORD_W-1:0]           master_o,
    output logic                        host_req_o
);
    localparam logic [WORD_W-1:0] KEEP = used_bits(MAP) | (WORD_W'(1) << (WORD_W-1));

    logic             en_q;
    logic [SUM_W-1:0] sum_q, sum_n;
    logic             unused_wr_bits;

    assign unused_wr_bits = ^wr_data_i[WORD_W-2:0];

    mirq_map_eval #(.MAP(MAP)) u_eval (
        .child_vec_i (child_pend_i),
        .sum_o       (sum_n)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_q  <= 1'b0;
            sum_q <= '0;
        end else begin
            if (en_q)    sum_q <= sum_n;
            if (wr_en_i) en_q  <= wr_data_i[WORD_W-1];
        end
    end

    assign master_o = {en_q, sum_q};

    mirq_req_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_q),
        .any_i   (|sum_q),
        .pulse_o (host_req_o)
    );

    // R6: summary frozen while disabled
    assert_frozen_when_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q |=> $stable(master_o[SUM_W-1:0]));

    // R6: no request unless enabled in the cycle before
    assert_req_needs_en_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        host_req_o |-> $past(en_q));

    // R1: without a write the enable bit holds
    assert_en_holds_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_en_i |=> $stable(master_o[WORD_W-1]));

    // R5: unmapped bits stay zero
    assert_unmapped_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (master_o & ~KEEP) == '0);
endmodule

// File: tb/mirq_aggr_tb_top.sv
module mirq_aggr_tb_top;
    localparam int NC = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ch [NC];
    logic [NC*32-1:0] child_pend;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] master;
    logic        host_req;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;

    logic        m_en = 1'b0, m_hot = 1'b0, m_pulse = 1'b0;
    logic [30:0] m_sum = '0;

    always #4 clk = ~clk;

    always_comb
        for (int k = 0; k < NC; k++) child_pend[k*32 +: 32] = ch[k];

    mirq_aggr dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .child_pend_i (child_pend),
        .wr_en_i      (wr_en),
        .wr_data_i    (wr_data),
        .master_o     (master),
        .host_req_o   (host_req)
    );

    // Expected summary from the positions in R3 and R4
    function automatic logic [30:0] exp_sum();
        logic [30:0] s = '0;
        s[0]  = |ch[0][15:0];
        s[1]  = |ch[0][31:16];
        s[2]  = |ch[1][15:0];
        s[3]  = |ch[1][31:16];
        s[4]  = |ch[2][15:0];
        s[6]  = |ch[3][15:0];
        s[16] = |ch[4];
        s[17] = |ch[5];
        s[18] = |ch[6];
        s[20] = |ch[7];
        s[22] = |ch[8];
        s[23] = |ch[9];
        s[30] = |ch[10];
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic tick();
        logic        cond, n_en;
        logic [30:0] n_sum;
        cond  = m_en && (|m_sum);
        n_sum = m_en ? exp_sum() : m_sum;
        n_en  = wr_en ? wr_data[31] : m_en;
        @(posedge clk);
        m_pulse = cond && !m_hot;
        m_hot   = cond;
        m_sum   = n_sum;
        m_en    = n_en;
        @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk_model(input string tag);
        chk({tag, " master"}, master, {m_en, m_sum});
        chk({tag, " req"}, {31'b0, host_req}, {31'b0, m_pulse});
    endtask

    task automatic clr_all();
        for (int k = 0; k < NC; k++) ch[k] = '0;
    endtask

    initial begin
        int pos [7] = '{16, 17, 18, 20, 22, 23, 30};
        clr_all();
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 master after reset", master, 32'h0);
        chk("R8 req after reset", {31'b0, host_req}, 32'h0);
        rst_n = 1'b1;
        tick();

        // R1 garbage low bits, enable clear
        wr(32'h7FFF_FFFF);
        chk("R1 low write bits ignored", master, 32'h0);
        wr(32'h8000_0000);
        chk("R1 enable bit set", master, 32'h8000_0000);

        // R3 slices
        ch[0] = 32'h0001_0000; tick();
        chk("R3 group0 high half -> bit1", master, 32'h8000_0002);
        chk("R7 no pulse yet", {31'b0, host_req}, 32'h0);
        tick();
        chk("R7 pulse one clock later", {31'b0, host_req}, 32'h1);
        tick();
        chk("R7 pulse single cycle", {31'b0, host_req}, 32'h0);
        ch[0] = 32'h0000_0001; tick();
        chk("R2 bit1 clears bit0 sets", master, 32'h8000_0001);
        ch[0] = '0; ch[1] = 32'h8000_0000; tick();
        chk("R3 group1 high half -> bit3", master, 32'h8000_0008);
        ch[1] = 32'h0000_0004; tick();
        chk("R3 group1 low half -> bit2", master, 32'h8000_0004);
        ch[1] = '0; ch[2] = 32'hFFFF_0000; tick();
        chk("R3 group2 high half ignored", master, 32'h8000_0000);
        ch[2] = 32'h0000_8000; tick();
        chk("R3 group2 low half -> bit4", master, 32'h8000_0010);
        ch[2] = '0; ch[3] = 32'h0000_0100; tick();
        chk("R3 group3 low half -> bit6", master, 32'h8000_0040);
        ch[3] = 32'hFFFF_0000; tick();
        chk("R3 group3 high half ignored", master, 32'h8000_0000);
        ch[3] = '0; tick();

        // R4 whole-word groups
        for (int k = 4; k < NC; k++) begin
            ch[k] = 32'h8000_0000; tick();
            chk($sformatf("R4 group%0d -> bit%0d", k, pos[k-4]), master,
                32'h8000_0000 | (32'h1 << pos[k-4]));
            ch[k] = '0; tick();
            tick();
        end

        // R5 all ones
        for (int k = 0; k < NC; k++) ch[k] = '1;
        tick();
        chk("R5 unmapped bits zero", master, 32'hC0D7_005F);
        tick();

        // R6 freeze while disabled
        wr(32'h0000_0000);
        chk_model("R6 disable write");
        clr_all(); tick();
        chk("R6 summary frozen", master, 32'h40D7_005F);
        repeat (3) begin
            tick();
            chk("R6 no request while off", {31'b0, host_req}, 32'h0);
        end

        // R9 re-enable over frozen pending bits
        wr(32'h8000_0000);
        tick();
        chk("R9 pulse after re-enable", {31'b0, host_req}, 32'h1);
        tick(); tick();
        chk("R2 bits cleared after re-enable", master, 32'h8000_0000);

        // Random phase against the model
        void'($urandom(32'd20240611));
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 4 == 0) begin
                int k;
                int sel;
                k = int'($urandom % NC);
                sel = int'($urandom % 3);
                ch[k] = (sel == 0) ? 32'h0 : (sel == 1) ? (32'h1 << ($urandom % 32)) : $urandom;
            end
            if ($urandom % 16 == 0) begin
                wr_en = 1'b1;
                wr_data = {($urandom % 4 != 0), 31'($urandom)};
            end
            tick();
            wr_en = 1'b0;
            chk_model("R2/R7 random");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule